// File: doc/BRIEF.md
# Hysteretic Thermal Throttle Controller

This block watches a unitless control-temperature sample and decides how hard the core should be held back. Each valid sample first has a signed sensor offset added and is then clamped to the sample range. The result is held as the current control temperature and compared against three programmable levels: a hardware throttle limit with a hysteresis band, a software alarm limit with its own band, and a critical trip level.

While the hardware channel is active, the block caps the performance state and gates the core clock for a few cycles out of every period. It also holds an active-low hot pin low. The software channel uses the same enter and exit rules but drives no pin. Instead it produces a one-cycle interrupt when it becomes active. The trip path latches until reset. It pulls an active-low trip pin, requests that all clocks stop, and overrides the periodic gate. A small register port exposes status and the effective exit thresholds, and it lets test software force the trip.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: On a cycle with `temp_vld_i` high, the adjusted temperature is `temp_i + offset_i` (offset signed), saturated to 0 and 255. It becomes the control temperature and is readable at status bits [15:8] one cycle later. Without a valid strobe the control temperature holds.
- R2: The hardware channel becomes active on a valid sample whose adjusted temperature is greater than or equal to `hw_limit_i`.
- R3: An active channel stays active until a valid sample is less than or equal to its exit threshold, and is then cleared. The exit threshold is limit minus hysteresis, or 0 when hysteresis exceeds the limit. It is readable at address 1: hardware exit in bits [7:0], software exit in bits [23:16].
- R4: `prochot_l_o` is low exactly while the hardware channel is active, and it is never driven by the software channel.
- R5: While the hardware channel is active, `pstate_cap_o` equals `pstate_lim_i`. Otherwise it is 0, which means uncapped.
- R6: While the hardware channel is active and no trip is latched, `clk_en_o` is low for the first 2 of every 8 cycles, starting in the cycle the channel becomes active. When the channel is inactive, `clk_en_o` is high.
- R7: A valid sample at or above `trip_lvl_i` with `trip_en_i` high latches the trip. The trip drives `thermtrip_l_o` low and `stop_clk_o` high until reset. With `trip_en_i` low, the sample is ignored.
- R8: A register write to address 0 with data bit 0 set forces the trip whatever the value of `trip_en_i`. Writes to any other address have no effect.
- R9: The software channel follows R2/R3 with `sw_limit_i`/`sw_hyst_i`. `sw_irq_o` pulses for one cycle when the channel becomes active.
- R10: A read of address 0 returns: bit 0 the trip enable, bit 1 the trip-sense flag, bit 2 hardware active, bit 3 software active, and [15:8] the control temperature. Addresses 2 and 3 read 0.
- R11: A latched trip takes priority over throttling: `clk_en_o` is low, even when the trip level is at or below the throttle limit.
- R12: Clearing a channel's enable makes that channel inactive at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| temp_i | input | 8 | Raw control-temperature sample |
| temp_vld_i | input | 1 | Sample valid strobe |
| offset_i | input | 6 | Signed sensor offset |
| hw_en_i | input | 1 | Hardware throttle enable |
| hw_limit_i | input | 8 | Hardware throttle limit |
| hw_hyst_i | input | 8 | Hardware hysteresis below limit |
| pstate_lim_i | input | 3 | P-state cap applied while throttling |
| sw_en_i | input | 1 | Software alarm enable |
| sw_limit_i | input | 8 | Software alarm limit |
| sw_hyst_i | input | 8 | Software hysteresis below limit |
| trip_en_i | input | 1 | Critical trip enable |
| trip_lvl_i | input | 8 | Critical trip level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| pstate_cap_o | output | 3 | P-state cap, 0 when uncapped |
| clk_en_o | output | 1 | Core clock enable (low gates) |
| prochot_l_o | output | 1 | Active-low hot indication |
| thermtrip_l_o | output | 1 | Active-low critical trip |
| stop_clk_o | output | 1 | Stop-all-clocks request |
| sw_irq_o | output | 1 | Software alarm interrupt pulse |

## Verification
A wrong channel state shows up at `prochot_l_o`, `pstate_cap_o` and status bit 2 on the first edge after the offending sample. The bench therefore probes both sides of each threshold, including the saturated exit threshold of 0. A counter fault in the gate shows up as a wrong number of low cycles over two full periods. A trip latch that leaks appears as `thermtrip_l_o` returning high after a cool sample. That case is checked after cooling and again after a reset.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_EXIT   = 2'd1;

  localparam int unsigned ST_TRIP_EN  = 0;
  localparam int unsigned ST_TRIP     = 1;
  localparam int unsigned ST_HW_ACT   = 2;
  localparam int unsigned ST_SW_ACT   = 3;
  localparam int unsigned ST_TEMP_LSB = 8;
  localparam int unsigned EX_SW_LSB   = 16;
endpackage

// File: rtl/temp_adjust.sv
module temp_adjust #(
  parameter int unsigned TEMP_W = 8,
  parameter int unsigned OFF_W  = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     vld_i,
  input  logic        [TEMP_W-1:0] raw_i,
  input  logic signed [OFF_W-1:0]  off_i,
  output logic        [TEMP_W-1:0] adj_o,
  output logic        [TEMP_W-1:0] ctl_q_o
);
  localparam int unsigned SUM_W = ((TEMP_W > OFF_W) ? TEMP_W : OFF_W) + 2;
  localparam logic signed [SUM_W-1:0] MAX_V =
    $signed({{(SUM_W-TEMP_W){1'b0}}, {TEMP_W{1'b1}}});

  logic signed [SUM_W-1:0] sum;
  assign sum = $signed({{(SUM_W-TEMP_W){1'b0}}, raw_i})
             + $signed({{(SUM_W-OFF_W){off_i[OFF_W-1]}}, off_i});

  always_comb begin
    if (sum < 0)          adj_o = '0;
    else if (sum > MAX_V) adj_o = '1;
    else                  adj_o = sum[TEMP_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ctl_q_o <= '0;
    else if (vld_i) ctl_q_o <= adj_o;
  end

  p_ctl_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(ctl_q_o));
endmodule

// File: rtl/hyst_channel.sv
module hyst_channel #(
  parameter int unsigned TEMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              vld_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] limit_i,
  input  logic [TEMP_W-1:0] hyst_i,
  output logic [TEMP_W-1:0] exit_o,
  output logic              active_o
);
  // exit level saturates at zero on a band wider than the limit
  assign exit_o = (hyst_i > limit_i) ? '0 : limit_i - hyst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             active_o <= 1'b0;
    else if (!en_i)                          active_o <= 1'b0;
    else if (vld_i && !active_o && temp_i >= limit_i) active_o <= 1'b1;
    else if (vld_i &&  active_o && temp_i <= exit_o)  active_o <= 1'b0;
  end

  p_enter_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(en_i && vld_i && temp_i >= limit_i));

  p_exit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> $past(!en_i || (vld_i && temp_i <= exit_o)));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && en_i && vld_i && temp_i > exit_o) |=> active_o);

  p_disable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !active_o);
endmodule

// File: rtl/trip_latch.sv
module trip_latch #(
  parameter int unsigned TEMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              vld_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] trip_i,
  input  logic              force_i,
  output logic              trip_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trip_o <= 1'b0;
    else if (force_i || (en_i && vld_i && temp_i >= trip_i)) trip_o <= 1'b1;
  end

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o |=> trip_o);

  p_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_o) |-> $past(force_i || (en_i && vld_i && temp_i >= trip_i)));
endmodule

// File: rtl/throttle_gate.sv
module throttle_gate #(
  parameter int unsigned PERIOD = 8,
  parameter int unsigned ON_CYC = 2,
  parameter int unsigned PST_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             trip_i,
  input  logic [PST_W-1:0] pst_lim_i,
  output logic             clk_en_o,
  output logic [PST_W-1:0] pst_cap_o
);
  localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] ON_V = CNT_W'(ON_CYC);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!active_i)     cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    if (trip_i)         clk_en_o = 1'b0;
    else if (!active_i) clk_en_o = 1'b1;
    else                clk_en_o = (cnt_q >= ON_V);
  end

  assign pst_cap_o = active_i ? pst_lim_i : '0;

  p_cnt_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  p_cnt_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> cnt_q == '0);
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl
  import thermal_pkg::*;
#(
  parameter int unsigned TEMP_W = 8,
  parameter int unsigned OFF_W  = 6,
  parameter int unsigned PST_W  = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PERIOD = 8,
  parameter int unsigned ON_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              temp_vld_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic              hw_en_i,
  input  logic [TEMP_W-1:0] hw_limit_i,
  input  logic [TEMP_W-1:0] hw_hyst_i,
  input  logic [PST_W-1:0]  pstate_lim_i,
  input  logic              sw_en_i,
  input  logic [TEMP_W-1:0] sw_limit_i,
  input  logic [TEMP_W-1:0] sw_hyst_i,
  input  logic              trip_en_i,
  input  logic [TEMP_W-1:0] trip_lvl_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [PST_W-1:0]  pstate_cap_o,
  output logic              clk_en_o,
  output logic              prochot_l_o,
  output logic              thermtrip_l_o,
  output logic              stop_clk_o,
  output logic              sw_irq_o
);
  logic [TEMP_W-1:0] adj, ctl_q, hw_exit, sw_exit;
  logic hw_act, sw_act, sw_act_q, tripped, force_trip;
  logic unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:1];
  assign force_trip   = reg_wr_i && (reg_addr_i == ADDR_STATUS) && reg_wdata_i[0];

  temp_adjust #(.TEMP_W(TEMP_W), .OFF_W(OFF_W)) u_adj (
    .clk_i, .rst_ni, .vld_i(temp_vld_i), .raw_i(temp_i),
    .off_i($signed(offset_i)), .adj_o(adj), .ctl_q_o(ctl_q)
  );

  hyst_channel #(.TEMP_W(TEMP_W)) u_hw (
    .clk_i, .rst_ni, .en_i(hw_en_i), .vld_i(temp_vld_i), .temp_i(adj),
    .limit_i(hw_limit_i), .hyst_i(hw_hyst_i), .exit_o(hw_exit), .active_o(hw_act)
  );

  hyst_channel #(.TEMP_W(TEMP_W)) u_sw (
    .clk_i, .rst_ni, .en_i(sw_en_i), .vld_i(temp_vld_i), .temp_i(adj),
    .limit_i(sw_limit_i), .hyst_i(sw_hyst_i), .exit_o(sw_exit), .active_o(sw_act)
  );

  trip_latch #(.TEMP_W(TEMP_W)) u_trip (
    .clk_i, .rst_ni, .en_i(trip_en_i), .vld_i(temp_vld_i), .temp_i(adj),
    .trip_i(trip_lvl_i), .force_i(force_trip), .trip_o(tripped)
  );

  throttle_gate #(.PERIOD(PERIOD), .ON_CYC(ON_CYC), .PST_W(PST_W)) u_gate (
    .clk_i, .rst_ni, .active_i(hw_act), .trip_i(tripped),
    .pst_lim_i(pstate_lim_i), .clk_en_o(clk_en_o), .pst_cap_o(pstate_cap_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sw_act_q <= 1'b0;
    else         sw_act_q <= sw_act;
  end

  assign sw_irq_o      = sw_act && !sw_act_q;
  assign prochot_l_o   = !hw_act;
  assign thermtrip_l_o = !tripped;
  assign stop_clk_o    = tripped;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_STATUS: begin
        reg_rdata_o[ST_TRIP_EN]             = trip_en_i;
        reg_rdata_o[ST_TRIP]                = tripped;
        reg_rdata_o[ST_HW_ACT]              = hw_act;
        reg_rdata_o[ST_SW_ACT]              = sw_act;
        reg_rdata_o[ST_TEMP_LSB +: TEMP_W]  = ctl_q;
      end
      ADDR_EXIT: begin
        reg_rdata_o[0 +: TEMP_W]            = hw_exit;
        reg_rdata_o[EX_SW_LSB +: TEMP_W]    = sw_exit;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  p_irq_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_irq_o |=> !sw_irq_o);

  p_trip_stop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !thermtrip_l_o |-> !clk_en_o);

  p_hot_cap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prochot_l_o |-> pstate_cap_o == '0);
endmodule

// File: tb/sim_thermal_throttle_ctrl.sv
module sim_thermal_throttle_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  temp_i = '0;
  logic        temp_vld_i = 1'b0;
  logic [5:0]  offset_i = '0;
  logic        hw_en_i = 1'b1;
  logic [7:0]  hw_limit_i = 8'd100;
  logic [7:0]  hw_hyst_i = 8'd10;
  logic [2:0]  pstate_lim_i = 3'd3;
  logic        sw_en_i = 1'b1;
  logic [7:0]  sw_limit_i = 8'd80;
  logic [7:0]  sw_hyst_i = 8'd5;
  logic        trip_en_i = 1'b1;
  logic [7:0]  trip_lvl_i = 8'd120;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [2:0]  pstate_cap_o;
  logic        clk_en_o, prochot_l_o, thermtrip_l_o, stop_clk_o, sw_irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  thermal_throttle_ctrl u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; temp_vld_i = 1'b0; reg_wr_i = 1'b0;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic sample(input logic [7:0] t);
    temp_i = t; temp_vld_i = 1'b1;
    @(negedge clk_i);
    temp_vld_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr_i = a; #0.5; d = reg_rdata_o;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R4 reset prochot", prochot_l_o, 1);
    chk("R7 reset thermtrip", thermtrip_l_o, 1);
    chk("R7 reset stop", stop_clk_o, 0);
    chk("R6 reset clk_en", clk_en_o, 1);
    chk("R5 reset pstate", pstate_cap_o, 0);
    chk("R9 reset irq", sw_irq_o, 0);
    rd(2'd0, d); chk("R10 reset status", d, 32'h1);
  endtask

  task automatic t_offset();
    logic [31:0] d;
    offset_i = 6'(-5); sample(8'd104);
    chk("R1 offset below limit", prochot_l_o, 1);
    rd(2'd0, d); chk("R1 ctl temp", d[15:8], 99);
    offset_i = 6'd1; sample(8'd99);
    chk("R2 enter at limit", prochot_l_o, 0);
    offset_i = 6'd0;
    temp_vld_i = 1'b0; temp_i = 8'd0;
    @(negedge clk_i);
    rd(2'd0, d); chk("R1 hold without strobe", d[15:8], 100);
    sample(8'd91); chk("R3 hold above exit", prochot_l_o, 0);
    sample(8'd90); chk("R3 clear at exit", prochot_l_o, 1);
    offset_i = 6'(-20); sample(8'd10);
    rd(2'd0, d); chk("R1 saturate low", d[15:8], 0);
    trip_en_i = 1'b0; offset_i = 6'd31; sample(8'd250);
    rd(2'd0, d); chk("R1 saturate high", d[15:8], 255);
    chk("R7 disabled trip ignored", thermtrip_l_o, 1);
    trip_en_i = 1'b1; offset_i = 6'd0; sample(8'd0);
    rd(2'd0, d); chk("R10 status after cool", d, 32'h1);
  endtask

  task automatic t_throttle();
    int z = 0;
    logic [31:0] d;
    sample(8'd100);
    chk("R4 prochot low", prochot_l_o, 0);
    chk("R5 pstate cap", pstate_cap_o, 3);
    rd(2'd0, d); chk("R10 hw bit", d[2], 1);
    chk("R6 gate starts low", clk_en_o, 0);
    for (int i = 0; i < 16; i++) begin
      if (!clk_en_o) z++;
      @(negedge clk_i);
    end
    chk("R6 gated cycles in 2 periods", z, 4);
    sample(8'd50);
    chk("R4 prochot released", prochot_l_o, 1);
    chk("R5 pstate uncapped", pstate_cap_o, 0);
    chk("R6 clk_en idle", clk_en_o, 1);
    sample(8'd0);
  endtask

  task automatic t_sw();
    logic [31:0] d;
    sample(8'd80);
    chk("R9 irq pulse", sw_irq_o, 1);
    chk("R4 sw not on prochot", prochot_l_o, 1);
    rd(2'd0, d); chk("R10 sw bit", d[3], 1);
    @(negedge clk_i);
    chk("R9 irq single cycle", sw_irq_o, 0);
    sample(8'd76);
    rd(2'd0, d); chk("R9 sw hold", d[3], 1);
    chk("R9 no irq while held", sw_irq_o, 0);
    sample(8'd75);
    rd(2'd0, d); chk("R9 sw clear", d[3], 0);
    sample(8'd85);
    chk("R9 irq again", sw_irq_o, 1);
    sample(8'd0);
  endtask

  task automatic t_clamp();
    logic [31:0] d;
    rd(2'd1, d); chk("R3 exit thresholds", d, 32'h004B_005A);
    hw_hyst_i = 8'd120;
    rd(2'd1, d); chk("R3 exit floor", d[7:0], 0);
    sample(8'd100); chk("R3 clamp enter", prochot_l_o, 0);
    sample(8'd1);   chk("R3 clamp hold at 1", prochot_l_o, 0);
    sample(8'd0);   chk("R3 clamp clear at 0", prochot_l_o, 1);
    hw_hyst_i = 8'd10;
  endtask

  task automatic t_disable();
    logic [31:0] d;
    sample(8'd100); chk("R12 active before disable", prochot_l_o, 0);
    hw_en_i = 1'b0; @(negedge clk_i);
    chk("R12 disable clears", prochot_l_o, 1);
    sample(8'd110); chk("R12 disabled ignores sample", prochot_l_o, 1);
    hw_en_i = 1'b1; sample(8'd0);
    wr(2'd1, 32'h1);
    chk("R8 other address write ignored", thermtrip_l_o, 1);
    rd(2'd2, d); chk("R10 unused address reads 0", d, 0);
  endtask

  task automatic t_trip();
    logic [31:0] d;
    sample(8'd120);
    chk("R7 trip low", thermtrip_l_o, 0);
    chk("R7 stop request", stop_clk_o, 1);
    chk("R11 trip overrides gate", clk_en_o, 0);
    sample(8'd0);
    chk("R7 trip sticky", thermtrip_l_o, 0);
    rd(2'd0, d); chk("R10 trip sense", d[1:0], 2'b11);
    do_reset();
    chk("R7 reset clears trip", thermtrip_l_o, 1);
    trip_lvl_i = 8'd90; sample(8'd95);
    chk("R11 low trip level trips", thermtrip_l_o, 0);
    chk("R11 clk stopped", clk_en_o, 0);
    do_reset();
    trip_lvl_i = 8'd120; trip_en_i = 1'b0;
    wr(2'd0, 32'h1);
    chk("R8 forced trip", thermtrip_l_o, 0);
    rd(2'd0, d); chk("R8 status forced", d[1:0], 2'b10);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_offset();
    t_throttle();
    t_sw();
    t_clamp();
    t_disable();
    t_trip();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule